// File: doc/BRIEF.md
# Display Interrupt Aggregator

This block gathers display events from two pipes and condenses them into a single interrupt line. Each pipe owns a 32-bit status word. The lower half holds sticky event flags. The upper half holds an arm (enable) bit for each flag, sitting exactly 16 positions above it. Bit 31 is a plain storage bit. An event pulse from the pipe timing logic sets its flag whether or not it is armed. The armed flags of a pipe are ORed into a pipe-level signal. Only a rising edge of that signal can raise the pipe's bit in the cause register.

The top level has three registers: a cause register (write-1-to-clear), a block register (a set bit suppresses a cause bit) and an allow register. The interrupt output is a registered OR of the cause bits that are allowed and not blocked. The top level is edge-triggered. So an edge that arrives while the cause bit is blocked is lost for good. Nothing more reaches the cause register until software clears that pipe's pending flags and a new edge occurs. Software uses a simple register port: one write strobe, one read strobe, and read data that returns one cycle later with a valid flag.

Top module: `disp_irq_agg`

## Requirements
- R1: After a synchronous active-low reset, the block register reads all ones (0x3) and the allow register reads 0. The cause register (address 0) and both pipe status words (addresses 4 and 5) read 0, and `irq` is 0. The block register is at address 1 and the allow register at address 2.
- R2: A pulse on `evt_vblank[p]`, `evt_vstart[p]` or `evt_blc[p]` sets bit 0, 1 or 2 of the status word of pipe p (address 4+p). This happens at the next clock edge, whether or not the flag is armed.
- R3: Writing 1 to a pending flag clears it, and writing 0 leaves it unchanged. Arm bits 16..18 and bit 31 store the written value. Every other bit reads 0.
- R4: If an event pulse and a write-1-to-clear reach the same flag in the same cycle, the flag stays set.
- R5: Pipe p's cause bit is bit p. It is set one cycle after the OR of that pipe's armed pending flags rises, provided block bit p is 0 at that edge.
- R6: While that OR stays high, a cleared cause bit is not set again, even if further events arrive.
- R7: If block bit p is 1 when the OR rises, cause bit p stays 0. Clearing the block bit later does not set it while the OR stays high.
- R8: The cause register is write-1-to-clear, so writing back the value just read acknowledges it.
- R9: `irq` equals, one cycle later, the OR over all bits of cause AND allow AND NOT block.
- R10: A single write of arm bits combined with the same bits shifted down by 16 arms those flags and clears their pending state, without raising a cause bit.
- R11: Writing back a status word ANDed with 0x8000FFFF disarms all flags and clears every pending flag. Bit 31 is kept.
- R12: The two pipes are independent. An event on one pipe changes neither the status word nor the cause bit of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_vblank | input | NUM_PIPES | Per-pipe vertical-blank event pulse |
| evt_vstart | input | NUM_PIPES | Per-pipe start-of-vertical-blank event pulse |
| evt_blc | input | NUM_PIPES | Per-pipe backlight-control event pulse |
| reg_addr | input | ADDR_W | Register address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | REG_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | REG_W | Read data, valid the cycle after `rd_en` |
| rd_valid | output | 1 | Marks `rd_data` as valid |
| irq | output | 1 | Aggregated interrupt |

## Verification
The bench builds the block with its defaults: two pipes, a 32-bit register width and a 3-bit address. With these values both status words sit at addresses 4 and 5, the 16-bit arm offset applies, and the keep bit sits at position 31. Cross-pipe independence and the 0x8000FFFF write-back can therefore be checked directly. The bench also exercises the lost-edge cases: a masked rise, a re-arm while the pipe OR is high, and an event colliding with a clear.

// File: rtl/dia_pkg.sv
// Package: shared constants for the display interrupt aggregator.
// Assumes a status word of at least 20 bits so that arm bits and the keep bit fit.
package dia_pkg;
    // Number of event kinds per pipe, and each kind's flag position in the low half.
    localparam int NUM_EV  = 3;
    localparam int EV_VBL  = 0;
    localparam int EV_VST  = 1;
    localparam int EV_BLC  = 2;

    // Register addresses.
    localparam int ADDR_CAUSE     = 0;
    localparam int ADDR_BLOCK     = 1;
    localparam int ADDR_ALLOW     = 2;
    localparam int ADDR_PIPE_BASE = 4;
endpackage

// File: rtl/dia_pipe_stat.sv
// Module: one pipe's status word.
// The low half holds sticky event flags, cleared by writing 1. An event arriving
// in the same cycle as a clear wins. The arm bits sit 16 above their flags, and
// bit REG_W-1 is plain storage. any_o is the OR of the armed pending flags.
// Assumes event inputs are single-cycle pulses.
module dia_pipe_stat
    import dia_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] evt,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  stat_o,
    output logic              any_o
);
    localparam int HALF = REG_W / 2;

    logic [NUM_EV-1:0] pend_q;
    logic [NUM_EV-1:0] arm_q;
    logic              keep_q;
    logic [NUM_EV-1:0] clr_mask;
    logic              unused_wr_bits;

    assign clr_mask = {NUM_EV{wr_en}} & wr_data[NUM_EV-1:0];
    assign unused_wr_bits = ^{wr_data[HALF-1:NUM_EV], wr_data[REG_W-2:HALF+NUM_EV]};

    // Purpose: update the pending flags, the arm bits and the keep bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            arm_q  <= '0;
            keep_q <= 1'b0;
        end else begin
            pend_q <= evt | (pend_q & ~clr_mask);
            if (wr_en) begin
                arm_q  <= wr_data[HALF +: NUM_EV];
                keep_q <= wr_data[REG_W-1];
            end
        end
    end

    // Purpose: assemble the readable status word.
    always_comb begin
        stat_o                 = '0;
        stat_o[NUM_EV-1:0]     = pend_q;
        stat_o[HALF +: NUM_EV] = arm_q;
        stat_o[REG_W-1]        = keep_q;
    end

    // Purpose: level seen by the top-level edge detector.
    assign any_o = |(pend_q & arm_q);
endmodule

// File: rtl/dia_rise_det.sv
// Module: per-bit rising-edge detector.
// rise_o is high for one cycle when lvl_i goes from 0 to 1.
// Assumes lvl_i comes from registered logic in the same clock domain.
module dia_rise_det #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] prev_q;

    // Purpose: remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    // Purpose: flag 0-to-1 transitions.
    assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/dia_irq_core.sv
// Module: cause, block and allow registers, plus the interrupt output.
// A cause bit is set by set_i unless its block bit is 1, and cleared by writing 1.
// A set wins over a clear in the same cycle. irq_o is the registered OR of the
// cause bits that are allowed and not blocked.
// Assumes set_i is a one-cycle edge pulse.
module dia_irq_core #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic             wr_cause,
    input  logic             wr_block,
    input  logic             wr_allow,
    input  logic [WIDTH-1:0] wr_bits,
    output logic [WIDTH-1:0] cause_o,
    output logic [WIDTH-1:0] block_o,
    output logic [WIDTH-1:0] allow_o,
    output logic             irq_o
);
    logic [WIDTH-1:0] cause_q;
    logic [WIDTH-1:0] block_q;
    logic [WIDTH-1:0] allow_q;
    logic             irq_q;
    logic [WIDTH-1:0] ack_bits;

    assign ack_bits = {WIDTH{wr_cause}} & wr_bits;

    // Purpose: latch unblocked edges and apply write-1-to-clear acknowledges.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= (cause_q & ~ack_bits) | (set_i & ~block_q);
    end

    // Purpose: software-written block and allow registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            block_q <= '1;
            allow_q <= '0;
        end else begin
            if (wr_block) block_q <= wr_bits;
            if (wr_allow) allow_q <= wr_bits;
        end
    end

    // Purpose: registered interrupt output.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(cause_q & allow_q & ~block_q);
    end

    assign cause_o = cause_q;
    assign block_o = block_q;
    assign allow_o = allow_q;
    assign irq_o   = irq_q;
endmodule

// File: rtl/disp_irq_agg.sv
// Module: top of the two-level display interrupt aggregator.
// It decodes the register port, builds one status word per pipe, detects rising
// edges of each pipe's armed-flag OR, and feeds them to the cause/interrupt core.
// Reads return one cycle after rd_en.
// Assumes at most one of wr_en and rd_en per cycle matters for a given address.
module disp_irq_agg
    import dia_pkg::*;
#(
    parameter int NUM_PIPES = 2,
    parameter int REG_W     = 32,
    parameter int ADDR_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PIPES-1:0] evt_vblank,
    input  logic [NUM_PIPES-1:0] evt_vstart,
    input  logic [NUM_PIPES-1:0] evt_blc,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_data,
    input  logic                 rd_en,
    output logic [REG_W-1:0]     rd_data,
    output logic                 rd_valid,
    output logic                 irq
);
    localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(ADDR_CAUSE);
    localparam logic [ADDR_W-1:0] A_BLOCK = ADDR_W'(ADDR_BLOCK);
    localparam logic [ADDR_W-1:0] A_ALLOW = ADDR_W'(ADDR_ALLOW);

    logic [NUM_PIPES-1:0]            pipe_any;
    logic [NUM_PIPES-1:0]            pipe_rise;
    logic [NUM_PIPES-1:0][REG_W-1:0] stat_w;
    logic [NUM_PIPES-1:0]            cause_w;
    logic [NUM_PIPES-1:0]            block_w;
    logic [NUM_PIPES-1:0]            allow_w;
    logic [REG_W-1:0]                rd_mux;
    logic [REG_W-1:0]                rd_q;
    logic                            rd_v_q;

    // One status word per pipe.
    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
        localparam logic [ADDR_W-1:0] A_PIPE = ADDR_W'(ADDR_PIPE_BASE + p);
        logic [NUM_EV-1:0] evt_vec;
        logic              wr_hit;

        // Purpose: gather this pipe's event pulses into flag order.
        always_comb begin
            evt_vec         = '0;
            evt_vec[EV_VBL] = evt_vblank[p];
            evt_vec[EV_VST] = evt_vstart[p];
            evt_vec[EV_BLC] = evt_blc[p];
        end

        assign wr_hit = wr_en && (reg_addr == A_PIPE);

        dia_pipe_stat #(.REG_W(REG_W)) u_stat (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (evt_vec),
            .wr_en   (wr_hit),
            .wr_data (wr_data),
            .stat_o  (stat_w[p]),
            .any_o   (pipe_any[p])
        );
    end

    dia_rise_det #(.WIDTH(NUM_PIPES)) u_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (pipe_any),
        .rise_o (pipe_rise)
    );

    dia_irq_core #(.WIDTH(NUM_PIPES)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (pipe_rise),
        .wr_cause (wr_en && (reg_addr == A_CAUSE)),
        .wr_block (wr_en && (reg_addr == A_BLOCK)),
        .wr_allow (wr_en && (reg_addr == A_ALLOW)),
        .wr_bits  (wr_data[NUM_PIPES-1:0]),
        .cause_o  (cause_w),
        .block_o  (block_w),
        .allow_o  (allow_w),
        .irq_o    (irq)
    );

    // Purpose: select the addressed register for a read.
    always_comb begin
        rd_mux = '0;
        if (reg_addr == A_CAUSE) rd_mux = REG_W'(cause_w);
        if (reg_addr == A_BLOCK) rd_mux = REG_W'(block_w);
        if (reg_addr == A_ALLOW) rd_mux = REG_W'(allow_w);
        for (int p = 0; p < NUM_PIPES; p++) begin
            if (reg_addr == ADDR_W'(ADDR_PIPE_BASE + p)) rd_mux = stat_w[p];
        end
    end

    // Purpose: register read data and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= '0;
            rd_v_q <= 1'b0;
        end else begin
            rd_v_q <= rd_en;
            if (rd_en) rd_q <= rd_mux;
        end
    end

    assign rd_data  = rd_q;
    assign rd_valid = rd_v_q;
endmodule

// File: rtl/dia_checker.sv
// Module: assertion checker bound into disp_irq_agg.
// It observes the ports and the signals that pass between the sub-blocks.
module dia_checker
    import dia_pkg::*;
#(
    parameter int NUM_PIPES = 2,
    parameter int REG_W     = 32
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [NUM_PIPES-1:0]            evt_vblank,
    input logic [NUM_PIPES-1:0][REG_W-1:0] stat_w,
    input logic [NUM_PIPES-1:0]            cause_w,
    input logic [NUM_PIPES-1:0]            block_w,
    input logic [NUM_PIPES-1:0]            allow_w,
    input logic                            irq
);
    localparam int HALF = REG_W / 2;

    logic [NUM_PIPES-1:0] lvl;
    logic [NUM_PIPES-1:0] lvl_d;
    logic                 irq_want;
    logic                 unused_chk;

    assign unused_chk = ^stat_w;
    assign irq_want   = |(cause_w & allow_w & ~block_w);

    // Purpose: checker's own view of each pipe's armed-flag OR.
    always_comb begin
        for (int p = 0; p < NUM_PIPES; p++)
            lvl[p] = |(stat_w[p][NUM_EV-1:0] & stat_w[p][HALF +: NUM_EV]);
    end

    // Purpose: last cycle's level, for edge reasoning.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= '0;
        else        lvl_d <= lvl;
    end

    // R1: reset values.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!irq && cause_w == '0 && block_w == '1 && allow_w == '0));

    // R9: the output follows the gated cause bits one cycle later.
    a_r9_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
        irq_want |=> irq);
    a_r9_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_want |=> !irq);

    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_chk
        // R2, R4: an event always leaves its flag set.
        a_r2_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
            evt_vblank[p] |=> stat_w[p][EV_VBL]);
        // R5, R6: a cause bit rises only after a fresh rise of the pipe level.
        a_r5_cause_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cause_w[p]) |-> ($past(lvl[p]) && !$past(lvl_d[p])));
        // R7: a blocked cause bit cannot be set.
        a_r7_block_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (block_w[p] && !cause_w[p]) |=> !cause_w[p]);
    end
endmodule

bind disp_irq_agg dia_checker #(.NUM_PIPES(NUM_PIPES), .REG_W(REG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_vblank (evt_vblank),
    .stat_w     (stat_w),
    .cause_w    (cause_w),
    .block_w    (block_w),
    .allow_w    (allow_w),
    .irq        (irq)
);

// File: tb/disp_irq_agg_test.sv
// Bench: scoreboard. Read tasks push expected values into a queue, and a monitor
// pops and compares them when rd_valid is high.
module disp_irq_agg_test;
    localparam int NP = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] evt_vblank = '0;
    logic [NP-1:0] evt_vstart = '0;
    logic [NP-1:0] evt_blc = '0;
    logic [2:0]    reg_addr = '0;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic          rd_en = 1'b0;
    logic [31:0]   rd_data;
    logic          rd_valid;
    logic          irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    disp_irq_agg uut (
        .clk(clk), .rst_n(rst_n),
        .evt_vblank(evt_vblank), .evt_vstart(evt_vstart), .evt_blc(evt_blc),
        .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .irq(irq)
    );

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        reg_addr = a; rd_en = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // kind: 0 vblank, 1 start-of-vblank, 2 backlight
    task automatic pulse(input int kind, input int p);
        @(negedge clk);
        if (kind == 0) evt_vblank[p] = 1'b1;
        if (kind == 1) evt_vstart[p] = 1'b1;
        if (kind == 2) evt_blc[p]    = 1'b1;
        @(negedge clk);
        evt_vblank = '0; evt_vstart = '0; evt_blc = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_irq(input logic e, input string t);
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s irq actual %0b expected %0b", t, irq, e);
        end
    endtask

    // Monitor: compare each returned read with the head of the scoreboard.
    always @(negedge clk) begin
        if (rd_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read data actual %08h expected none", rd_data);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    errors++;
                    $display("FAIL %s read actual %08h expected %08h", t, rd_data, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        // R1 reset state
        rd(3'd0, 32'h0, "R1 cause");
        rd(3'd1, 32'h3, "R1 block");
        rd(3'd2, 32'h0, "R1 allow");
        rd(3'd4, 32'h0, "R1 pipe0");
        rd(3'd5, 32'h0, "R1 pipe1");
        chk_irq(1'b0, "R1");

        wr(3'd1, 32'h0);
        wr(3'd2, 32'h3);
        // R2: an unarmed event still sets its flag, but no cause bit
        pulse(0, 0);
        rd(3'd4, 32'h0000_0001, "R2 unarmed flag");
        rd(3'd0, 32'h0, "R2 no cause while unarmed");
        // R3: write-0 keeps, write-1 clears, arm and keep bits store
        wr(3'd4, 32'h0);
        rd(3'd4, 32'h0000_0001, "R3 write0 keeps");
        wr(3'd4, 32'h1);
        rd(3'd4, 32'h0, "R3 write1 clears");
        wr(3'd4, 32'hFFFF_0000);
        rd(3'd4, 32'h8007_0000, "R3 arm bits and keep bit");
        wr(3'd4, 32'h0);
        rd(3'd4, 32'h0, "R3 clear arms");
        // R10: combined arm + clear
        wr(3'd4, 32'h0001_0001);
        rd(3'd4, 32'h0001_0000, "R10 armed no pending");
        rd(3'd0, 32'h0, "R10 no cause");
        // R5, R9: edge sets cause, irq follows one cycle later
        pulse(0, 0);
        chk_irq(1'b0, "R9 before cause");
        idle(1);
        chk_irq(1'b0, "R9 registered delay");
        idle(1);
        chk_irq(1'b1, "R9 irq raised");
        rd(3'd0, 32'h1, "R5 cause set");
        // R8: write back acknowledges
        wr(3'd0, 32'h1);
        rd(3'd0, 32'h0, "R8 ack clears cause");
        chk_irq(1'b0, "R8 irq drops");
        // R6: level stays high, new event gives no cause
        pulse(0, 0);
        rd(3'd0, 32'h0, "R6 no re-trigger on level");
        rd(3'd4, 32'h0001_0001, "R6 flag still pending");
        // R7: blocked edge is lost
        wr(3'd4, 32'h0001_0001);
        wr(3'd1, 32'h1);
        pulse(0, 0);
        idle(2);
        rd(3'd0, 32'h0, "R7 blocked edge");
        wr(3'd1, 32'h0);
        idle(2);
        rd(3'd0, 32'h0, "R7 unblock does not recover");
        chk_irq(1'b0, "R7 irq stays low");
        wr(3'd4, 32'h0001_0001);
        pulse(0, 0);
        rd(3'd0, 32'h1, "R7 fresh edge after clear");
        wr(3'd0, 32'h1);
        wr(3'd4, 32'h0001_0001);
        // R4: event and clear in the same cycle
        @(negedge clk);
        evt_vblank[0] = 1'b1;
        reg_addr = 3'd4; wr_data = 32'h0001_0001; wr_en = 1'b1;
        @(negedge clk);
        evt_vblank = '0; wr_en = 1'b0;
        rd(3'd4, 32'h0001_0001, "R4 event wins over clear");
        wr(3'd4, 32'h0001_0001);
        wr(3'd0, 32'h1);
        rd(3'd0, 32'h0, "R4 cleanup cause");
        // R12, R9: pipe 1 alone, allow gating
        wr(3'd2, 32'h1);
        wr(3'd5, 32'h0006_0006);
        pulse(2, 1);
        rd(3'd0, 32'h2, "R12 pipe1 cause bit");
        rd(3'd4, 32'h0001_0000, "R12 pipe0 untouched");
        rd(3'd5, 32'h0006_0004, "R12 pipe1 backlight flag");
        chk_irq(1'b0, "R9 allow gates irq");
        wr(3'd2, 32'h3);
        chk_irq(1'b0, "R9 allow delay");
        idle(1);
        chk_irq(1'b1, "R9 allowed irq");
        // R11: keep bit survives 0x8000FFFF write-back
        wr(3'd5, 32'h8006_0000);
        rd(3'd5, 32'h8006_0004, "R11 keep bit set");
        wr(3'd5, 32'h8006_0004 & 32'h8000_FFFF);
        rd(3'd5, 32'h8000_0000, "R11 disarm and clear");
        wr(3'd0, 32'h2);
        idle(1);
        chk_irq(1'b0, "R8 final ack");
        idle(3);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard actual %0d left expected 0", exp_q.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule